// File: doc/BRIEF.md
# Strap-Configurable Host Bus Slave

This block lets an external microprocessor reach a small set of internal registers and feed a byte-wide stream FIFO. Three strap pins are captured while reset is held. They choose the bus width (8 or 16 data lines), the byte order for 16-bit transfers, and one of two handshake styles. In the first style, a direction line is paired with a single data strobe. In the second, separate read and write strobes are used.

Every host strobe passes through a two-flop synchronizer. An access takes effect on the synchronized falling edge of its strobe.

A shared acknowledge pin behaves according to the handshake style:
- In the direction/strobe style, it reports completion.
- In the split-strobe style, it acts as a wait line.

Stream writes are paced per packet by a ready flag. An active-low interrupt request reports unmasked status bits. The consumer side drains the FIFO through a pop port.

Top module: `hbus_slave`

## Requirements
- R1: The width, byte-order and style straps are captured only while rst_ni is low. Changing them afterwards has no effect until the next reset.
- R2: With the width strap low, only hd_i[7:0] carries data and hd_o[15:8] reads as zero.
- R3: With the width strap high, byte-order strap low puts the most significant byte of a 16-bit value on lines 15:8. Strap high puts it on lines 7:0.
- R4: Style strap low selects the direction/strobe handshake:
  - ctl_a_i high means read, low means write.
  - ctl_b_i is the active-low strobe.
  - ack_oe_o is high with ack_no low from the cycle the access is taken until the released strobe has been synchronized. ack_oe_o is low at all other times.
- R5: Style strap high selects the split-strobe handshake:
  - ctl_a_i is the active-low write strobe.
  - ctl_b_i is the active-low read strobe.
  - ack_oe_o is always high.
  - ack_no is a wait line. It is low from the instant a strobe is seen until the access has been taken, and high otherwise.
- R6: An access is taken at the third rising clock edge after its strobe falls. Read data is driven on hd_o with hd_oe_o high from that edge until the access ends.
- R7: Register map:
  - Address 0 is the write-only stream port and reads as zero.
  - Address 1 is interrupt status. Reading it clears it, and writes to it are ignored.
  - Address 2 is the mask. A set bit masks that source, and the reset value is all ones.
  - Address 3 is the burst length in bytes, with a reset value of 8.
  - Addresses 4 to 15 read as zero and ignore writes.
- R8: A pulse on irq_src_i sets the matching status bit. While any status bit is set and unmasked, irq_no is low and irq_oe_o is high; otherwise irq_oe_o is low and irq_no is high. The request drops after a status read or after the set bits are masked.
- R9: A stream write pushes one byte in 8-bit mode. In 16-bit mode it pushes two bytes, most significant first. The FIFO pops in write order, with st_data_o showing the oldest byte.
- R10: rdy_o is re-evaluated one cycle after every edge that leaves no partial packet pending. It is then high exactly when the free FIFO space is at least the burst length. Inside a packet it holds its value. Writing the burst length restarts packet counting.
- R11: A stream write that does not entirely fit in the free space is dropped, leaving FIFO contents and packet count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; straps sampled while low |
| strap_wide_i | input | 1 | Bus width strap: 0 = 8 bits, 1 = 16 bits |
| strap_swap_i | input | 1 | Byte order strap: 1 = most significant byte on lines 7:0 |
| strap_sep_i | input | 1 | Handshake style strap: 0 = direction/strobe, 1 = split strobes |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 4 | Register address |
| ctl_a_i | input | 1 | Direction (style 0) or write strobe, active low (style 1) |
| ctl_b_i | input | 1 | Data strobe (style 0) or read strobe (style 1), active low |
| hd_i | input | 16 | Host data toward the block |
| hd_o | output | 16 | Host read data |
| hd_oe_o | output | 1 | Drive enable for hd_o |
| ack_no | output | 1 | Completion (style 0) or wait (style 1), active low |
| ack_oe_o | output | 1 | Drive enable for ack_no |
| rdy_o | output | 1 | Room for one more stream packet |
| irq_no | output | 1 | Interrupt request, active low |
| irq_oe_o | output | 1 | Drive enable for irq_no |
| irq_src_i | input | IW | Interrupt event pulses |
| st_pop_i | input | 1 | Remove the oldest stream byte |
| st_data_o | output | 8 | Oldest stream byte |
| st_empty_o | output | 1 | Stream FIFO is empty |

## Verification
- **Register and FIFO effects:** results land exactly three rising edges after the host strobe falls. The bench checks just after the second edge that nothing has been driven yet, then checks data and acknowledge at the falling edge following the third.
- **Wait line:** in the split-strobe style the wait line answers combinationally, so it is checked one nanosecond after the strobe is applied.
- **Ready flag:** it lags a packet boundary by one further edge. The behavioural model updates its ready value one posedge after its packet count returns to zero.
- **Every-cycle comparison:** the model's interrupt line, FIFO head and empty flag are compared at every falling edge.

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int IW       = 8,
  parameter int DEPTH    = 16,
  parameter int BLEN_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_wide_i,
  input  logic          strap_swap_i,
  input  logic          strap_sep_i,
  input  logic          cs_ni,
  input  logic [3:0]    addr_i,
  input  logic          ctl_a_i,
  input  logic          ctl_b_i,
  input  logic [15:0]   hd_i,
  output logic [15:0]   hd_o,
  output logic          hd_oe_o,
  output logic          ack_no,
  output logic          ack_oe_o,
  output logic          rdy_o,
  output logic          irq_no,
  output logic          irq_oe_o,
  input  logic [IW-1:0] irq_src_i,
  input  logic          st_pop_i,
  output logic [7:0]    st_data_o,
  output logic          st_empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic cfg_wide, cfg_swap, cfg_sep;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) {cfg_wide, cfg_swap, cfg_sep} <= {strap_wide_i, strap_swap_i, strap_sep_i};

  logic [1:0] a_s, b_s, c_s;
  logic       act_d, done, rd_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      a_s <= 2'b11; b_s <= 2'b11; c_s <= 2'b11;
    end else begin
      a_s <= {a_s[0], ctl_a_i};
      b_s <= {b_s[0], ctl_b_i};
      c_s <= {c_s[0], cs_ni};
    end

  wire raw_act = ~cs_ni & (cfg_sep ? (~ctl_a_i | ~ctl_b_i) : ~ctl_b_i);
  wire act     = ~c_s[1] & (cfg_sep ? (~a_s[1] | ~b_s[1]) : ~b_s[1]);
  wire is_rd   = cfg_sep ? ~b_s[1] : a_s[1];
  wire go      = act & ~act_d;
  wire go_rd   = go & is_rd;
  wire go_wr   = go & ~is_rd;

  wire [15:0] win = !cfg_wide ? {8'h00, hd_i[7:0]} :
                    cfg_swap  ? {hd_i[7:0], hd_i[15:8]} : hd_i;

  logic [IW-1:0] stat, mask;
  logic [7:0]    blen, pc;
  logic [15:0]   rq, rv;

  always_comb begin
    case (addr_i)
      4'd1:    rv = 16'(stat);
      4'd2:    rv = 16'(mask);
      4'd3:    rv = {8'h00, blen};
      default: rv = 16'h0000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_d <= 1'b0; done <= 1'b0; rd_q <= 1'b0; rq <= '0;
    end else begin
      act_d <= act;
      if (go) begin
        done <= 1'b1;
        rd_q <= is_rd;
        rq   <= is_rd ? rv : 16'h0000;
      end else if (!act) begin
        done <= 1'b0;
        rd_q <= 1'b0;
      end
    end

  assign hd_o     = !cfg_wide ? {8'h00, rq[7:0]} : cfg_swap ? {rq[7:0], rq[15:8]} : rq;
  assign hd_oe_o  = done & rd_q;
  assign ack_oe_o = cfg_sep ? 1'b1 : done;
  assign ack_no   = cfg_sep ? ~(raw_act & ~done) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stat <= '0; mask <= '1;
    end else begin
      stat <= ((go_rd && addr_i == 4'd1) ? '0 : stat) | irq_src_i;
      if (go_wr && addr_i == 4'd2) mask <= win[IW-1:0];
    end

  wire pend = |(stat & ~mask);
  assign irq_no   = ~pend;
  assign irq_oe_o = pend;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire [CW-1:0] free   = CW'(DEPTH) - cnt;
  wire [1:0]    n_req  = cfg_wide ? 2'd2 : 2'd1;
  wire          wr_st  = go_wr && addr_i == 4'd0;
  wire          fits   = free >= CW'(n_req);
  wire [1:0]    n_push = (wr_st && fits) ? n_req : 2'd0;
  wire          pop_ok = st_pop_i && cnt != '0;
  wire [7:0]    b0     = cfg_wide ? win[15:8] : win[7:0];
  wire [8:0]    pnx    = {1'b0, pc} + {7'd0, n_push};

  always_ff @(posedge clk_i)
    if (n_push != 2'd0) begin
      mem[wp] <= b0;
      if (cfg_wide) mem[AW'(wp + AW'(1))] <= win[7:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt <= '0;
      blen <= 8'(BLEN_RST); pc <= '0; rdy_o <= 1'b0;
    end else begin
      wp  <= AW'(wp + AW'(n_push));
      rp  <= AW'(rp + AW'(pop_ok));
      cnt <= cnt + CW'(n_push) - CW'(pop_ok);
      if (pc == 8'd0) rdy_o <= 32'(free) >= 32'(blen);
      if (go_wr && addr_i == 4'd3) begin
        blen <= win[7:0];
        pc   <= '0;
      end else if (n_push != 2'd0) begin
        pc <= (pnx >= {1'b0, blen}) ? 8'd0 : pnx[7:0];
      end
    end

  assign st_data_o  = mem[rp];
  assign st_empty_o = cnt == '0;

  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable({cfg_wide, cfg_swap, cfg_sep})); // R1
  AST_ACK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_sep && go) |=> (ack_oe_o && !ack_no)); // R4
  AST_WAIT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sep && go) |=> ack_no); // R5
  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_rd && addr_i == 4'd1 && irq_src_i == '0) |=> !irq_oe_o); // R8
  AST_RDY_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(pc) == 8'd0); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R11
endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_wide = 1'b0, s_swap = 1'b0, s_sep = 1'b0;
  logic cs_n = 1'b1, ca = 1'b1, cb = 1'b1, pop = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] hdi = '0, hdo;
  logic [7:0]  src = '0, sdat;
  logic hoe, ackn, ackoe, rdy, irqn, irqoe, sempty;

  always #4 clk = ~clk;

  hbus_slave i_hbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .strap_wide_i(s_wide), .strap_swap_i(s_swap),
    .strap_sep_i(s_sep), .cs_ni(cs_n), .addr_i(addr), .ctl_a_i(ca), .ctl_b_i(cb),
    .hd_i(hdi), .hd_o(hdo), .hd_oe_o(hoe), .ack_no(ackn), .ack_oe_o(ackoe),
    .rdy_o(rdy), .irq_no(irqn), .irq_oe_o(irqoe), .irq_src_i(src),
    .st_pop_i(pop), .st_data_o(sdat), .st_empty_o(sempty));

  int n_chk = 0, n_fail = 0;
  bit fin = 0;
  bit m_wide, m_swap, m_sep, m_rdy;
  bit [7:0] m_stat, m_mask, m_blen, m_pc;
  byte unsigned q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  always @(posedge clk)
    if (rst_n) begin
      if (m_pc == 0) m_rdy <= (DEPTH - q.size()) >= m_blen;
      m_stat = m_stat | src;
      if (pop && q.size() > 0) void'(q.pop_front());
    end

  always @(negedge clk)
    if (rst_n && !fin) begin
      chk(irqn == !(|(m_stat & ~m_mask)), "R8 irq line", irqn, !(|(m_stat & ~m_mask)));
      chk(irqoe == (|(m_stat & ~m_mask)), "R8 irq enable", irqoe, |(m_stat & ~m_mask));
      chk(rdy == m_rdy, "R10 ready", rdy, m_rdy);
      chk(sempty == (q.size() == 0), "R9 empty", sempty, q.size() == 0);
      if (q.size() > 0) chk(sdat == q[0], "R9 head", sdat, q[0]);
    end

  task automatic do_reset(input bit w, input bit s, input bit t);
    @(negedge clk);
    rst_n = 0; s_wide = w; s_swap = s; s_sep = t;
    m_wide = w; m_swap = s; m_sep = t;
    q.delete(); m_stat = 0; m_mask = 8'hFF; m_blen = 8; m_pc = 0; m_rdy = 0;
    repeat (3) @(negedge clk);
    chk(irqoe == 0 && rdy == 0 && sempty == 1 && hoe == 0, "R7 reset state",
        {irqoe, rdy, sempty, hoe}, 4'b0010);
    chk(ackoe == t, "R4 R5 reset ack enable", ackoe, t);
    rst_n = 1;
    @(negedge clk);
    s_wide = !w; s_swap = !s; s_sep = !t;   // R1: ignored after reset
  endtask

  function automatic bit [15:0] logic_word(input bit [15:0] d);
    if (!m_wide) return {8'h00, d[7:0]};
    if (m_swap) return {d[7:0], d[15:8]};
    return d;
  endfunction

  function automatic bit [15:0] bus_word(input bit [15:0] v);
    if (!m_wide) return {8'h00, v[7:0]};
    if (m_swap) return {v[7:0], v[15:8]};
    return v;
  endfunction

  task automatic acc(input bit rd, input bit [3:0] a, input bit [15:0] d, input string req);
    bit [15:0] lw, ev;
    int n;
    @(negedge clk);
    cs_n = 0; addr = a; hdi = d;
    if (!m_sep) begin ca = rd; cb = 0; end
    else if (rd) cb = 0; else ca = 0;
    if (m_sep) begin #1; chk(ackn == 0, "R5 wait on strobe", ackn, 0); end
    repeat (2) @(posedge clk);
    #1;
    chk(hoe == 0 && (m_sep || ackoe == 0), "R6 not taken after two edges", {hoe, ackoe}, {1'b0, m_sep});
    @(posedge clk);
    #1;
    lw = logic_word(d);
    ev = 0;
    if (rd) begin
      case (a)
        4'd1: begin ev = {8'h00, m_stat}; m_stat = 0; end
        4'd2: ev = {8'h00, m_mask};
        4'd3: ev = {8'h00, m_blen};
        default: ev = 0;
      endcase
    end else begin
      case (a)
        4'd0: begin
          n = m_wide ? 2 : 1;
          if (DEPTH - q.size() >= n) begin
            if (m_wide) begin q.push_back(lw[15:8]); q.push_back(lw[7:0]); end
            else q.push_back(lw[7:0]);
            m_pc = (m_pc + n >= m_blen) ? 0 : m_pc + n;
          end
        end
        4'd2: m_mask = lw[7:0];
        4'd3: begin m_blen = lw[7:0]; m_pc = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    if (!m_sep) chk(ackoe == 1 && ackn == 0, "R4 completion driven", {ackoe, ackn}, 2'b10);
    else chk(ackn == 1, "R5 wait released", ackn, 1);
    if (rd) begin
      chk(hoe == 1, "R6 read drive", hoe, 1);
      chk(hdo == bus_word(ev), req, hdo, bus_word(ev));
    end
    cs_n = 1; ca = 1; cb = 1;
    repeat (4) @(negedge clk);
    if (!m_sep) chk(ackoe == 0, "R4 ack released", ackoe, 0);
    chk(hoe == 0, "R6 bus released", hoe, 0);
  endtask

  task automatic pulse(input bit [7:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = 0;
    @(negedge clk);
  endtask

  task automatic pop_exp(input bit [7:0] e, input string req);
    @(negedge clk);
    chk(sdat == e && !sempty, req, sdat, e);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!fin) begin
      fin = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(0, 0, 0);
    acc(0, 4'd2, 16'h5AF0, "R2 mask write");
    acc(1, 4'd2, 16'hFFFF, "R1 R2 narrow mask readback");
    acc(1, 4'd3, 16'h0000, "R7 burst length reset");
    acc(1, 4'd9, 16'h0000, "R7 unmapped reads zero");
    acc(0, 4'd1, 16'h00FF, "R7 status write");
    acc(1, 4'd1, 16'h0000, "R7 status write ignored");
    acc(0, 4'd2, 16'h0000, "R8 unmask");
    pulse(8'h04);
    chk(irqn == 0 && irqoe == 1, "R8 request raised", {irqn, irqoe}, 2'b01);
    acc(1, 4'd1, 16'h0000, "R8 status read");
    chk(irqoe == 0, "R8 cleared by read", irqoe, 0);
    pulse(8'h10);
    acc(0, 4'd2, 16'h0010, "R8 mask bit");
    chk(irqoe == 0 && irqn == 1, "R8 cleared by mask", {irqn, irqoe}, 2'b10);
    acc(1, 4'd1, 16'h0000, "R8 masked status still set");
    for (int i = 0; i < 8; i++) acc(0, 4'd0, 16'hEE10 + 16'(i), "R9 stream");
    chk(rdy == 1, "R10 room after first packet", rdy, 1);
    for (int i = 0; i < 8; i++) acc(0, 4'd0, 16'h0020 + 16'(i), "R9 stream");
    chk(rdy == 0, "R10 ready drops when full", rdy, 0);
    acc(0, 4'd0, 16'h0099, "R11 overflow write");
    for (int i = 0; i < 8; i++) pop_exp(8'h10 + 8'(i), "R9 pop order");
    repeat (2) @(negedge clk);
    chk(rdy == 1, "R10 ready back after drain", rdy, 1);
    for (int i = 0; i < 8; i++) pop_exp(8'h20 + 8'(i), "R9 pop order");
    chk(sempty == 1, "R11 dropped byte absent", sempty, 1);

    do_reset(1, 0, 1);
    acc(0, 4'd3, 16'h0004, "R3 burst write");
    acc(1, 4'd3, 16'h0000, "R3 burst readback");
    acc(0, 4'd0, 16'hA1B2, "R9 wide stream");
    acc(0, 4'd0, 16'hC3D4, "R9 wide stream");
    pop_exp(8'hA1, "R9 most significant first");
    pop_exp(8'hB2, "R9 second byte");
    pop_exp(8'hC3, "R9 third byte");
    pop_exp(8'hD4, "R9 fourth byte");
    acc(1, 4'd2, 16'h0000, "R7 mask reset value");

    do_reset(1, 1, 1);
    acc(1, 4'd3, 16'h0000, "R3 swapped burst readback");
    acc(0, 4'd0, 16'hB2A1, "R3 swapped stream");
    pop_exp(8'hA1, "R3 swapped first byte");
    pop_exp(8'hB2, "R3 swapped second byte");

    do_reset(1, 1, 0);
    acc(0, 4'd2, 16'h3300, "R4 swapped mask write");
    acc(1, 4'd2, 16'h0000, "R4 swapped mask readback");
    repeat (4) @(negedge clk);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule